// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block owns the fetch program counter of a five-stage in-order pipeline and decides conditional branches while the branch sits in decode. Whenever a branch is in decode, the instruction right behind it has already been fetched at the current `pc_o`. That instruction is the delay slot, and it always runs: the block never squashes or flushes anything. The taken target is the delay-slot address plus the sign-extended offset scaled by four. Once decode is done, the branch does no further work in the later stages.

The comparator has its own copy of operand bypassing. It takes a non-load result waiting in the memory stage, or any result in writeback, in preference to the register-file read. A source written by the instruction now in execute cannot be bypassed in time, and neither can one written by a load in the memory stage. In both cases the block raises `stall_o`, holds the PC and issues no redirect until the value can be forwarded. An external `stall_i` also freezes the PC and suppresses redirects. Register 0 is treated as constant zero.

Top module: `br_resolve_top`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals RESET_PC (default 0), asynchronously. On each rising clock edge out of reset, `pc_o` takes the value `next_pc_o` had just before that edge.
- R2: For any opcode other than the equal-branch (6'h04) and not-equal-branch (6'h05) codes, `taken_o` is 0, `stall_o` is 0 and `next_pc_o` is `pc_o + 4`. This holds even when a source register matches a pending writer.
- R3: The equal branch (6'h04) with equal operands sets `taken_o` and drives `next_pc_o = pc_o + (imm << 2)`. With unequal operands, `taken_o` is 0 and `next_pc_o` is `pc_o + 4`.
- R4: The not-equal branch (6'h05) with unequal operands sets `taken_o` and drives `next_pc_o = pc_o + (imm << 2)`. With equal operands, `taken_o` is 0 and `next_pc_o` is `pc_o + 4`. Negative offsets move the PC backwards.
- R5: Each operand's select reads 0 for the register file, 1 for the memory-stage result and 2 for the writeback result. Memory is chosen when it writes that source as a non-load. Writeback is chosen when it writes that source and memory does not. The compare uses the selected value.
- R6: When both memory and writeback write the same source, the memory-stage value wins.
- R7: A branch whose source is written by the execute-stage instruction, or by a load in the memory stage, raises `stall_o`. It drives `taken_o` low and `next_pc_o = pc_o`.
- R8: Source register 0 never forwards, never stalls and always compares as its register-file value.
- R9: While `stall_i` is high, `taken_o` is 0 and `pc_o` holds. The branch resolves normally once `stall_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | External pipeline freeze |
| id_op_i | input | OP_W | Opcode of the instruction in decode |
| id_rs_i | input | RA_W | First source register index |
| id_rt_i | input | RA_W | Second source register index |
| id_rs_val_i | input | XLEN | Register-file value of first source |
| id_rt_val_i | input | XLEN | Register-file value of second source |
| id_imm_i | input | XLEN | Sign-extended branch offset in words |
| ex_wr_i | input | 1 | Execute-stage instruction writes a register |
| ex_rd_i | input | RA_W | Execute-stage destination |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_ld_i | input | 1 | Memory-stage instruction is a load |
| mem_rd_i | input | RA_W | Memory-stage destination |
| mem_val_i | input | XLEN | Memory-stage result (non-load) |
| wb_wr_i | input | 1 | Writeback instruction writes a register |
| wb_rd_i | input | RA_W | Writeback destination |
| wb_val_i | input | XLEN | Writeback result |
| pc_o | output | XLEN | Fetch PC (delay-slot address while a branch decodes) |
| next_pc_o | output | XLEN | PC loaded at the next edge |
| taken_o | output | 1 | Redirect issued this cycle |
| stall_o | output | 1 | Branch operand hazard, hold fetch and decode |
| fwd_a_o | output | 2 | Bypass select for first operand |
| fwd_b_o | output | 2 | Bypass select for second operand |

## Verification
Both branch opcodes are tried with equal and unequal operands and with positive and negative offsets. This separates a swapped condition from a wrong target computation. Operands arrive from the register file, from memory and from writeback on either side, and one case has memory and writeback racing for the same source. Those cases show whether the select, the priority and the compared value agree. Hazards come from an execute-stage writer and from a memory-stage load. Further cases cover register 0 with every writer pointing at it, a non-branch that matches a pending writer, and an external stall over a taken branch. These tell a genuine stall apart from over-eager stalling or a lost redirect.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    FWD_REG = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/br_opnd_fwd.sv
module br_opnd_fwd
  import br_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RA_W = 5
) (
  input  logic [RA_W-1:0] idx_i,
  input  logic [XLEN-1:0] rf_val_i,
  input  logic            ex_wr_i,
  input  logic [RA_W-1:0] ex_rd_i,
  input  logic            mem_wr_i,
  input  logic            mem_ld_i,
  input  logic [RA_W-1:0] mem_rd_i,
  input  logic [XLEN-1:0] mem_val_i,
  input  logic            wb_wr_i,
  input  logic [RA_W-1:0] wb_rd_i,
  input  logic [XLEN-1:0] wb_val_i,
  output logic [XLEN-1:0] val_o,
  output fwd_sel_e        sel_o,
  output logic            hazard_o
);
  logic live, ex_hit, mem_hit, wb_hit;

  // register 0 is hard zero: never matched
  assign live    = (idx_i != '0);
  assign ex_hit  = live && ex_wr_i  && (ex_rd_i  == idx_i);
  assign mem_hit = live && mem_wr_i && (mem_rd_i == idx_i);
  assign wb_hit  = live && wb_wr_i  && (wb_rd_i  == idx_i);

  // execute result and memory-stage load data arrive too late for decode
  assign hazard_o = ex_hit || (mem_hit && mem_ld_i);

  always_comb begin
    sel_o = FWD_REG;
    val_o = rf_val_i;
    if (mem_hit && !mem_ld_i) begin
      sel_o = FWD_MEM;
      val_o = mem_val_i;
    end else if (wb_hit && !mem_hit) begin
      sel_o = FWD_WB;
      val_o = wb_val_i;
    end
  end
endmodule

// File: rtl/br_cmp_npc.sv
module br_cmp_npc #(
  parameter int                XLEN   = 32,
  parameter int                OP_W   = 6,
  parameter logic [OP_W-1:0]   OP_BEQ = 6'h04,
  parameter logic [OP_W-1:0]   OP_BNE = 6'h05
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            hold_i,
  output logic            is_br_o,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic            is_beq, is_bne, same, cond;
  logic [XLEN-1:0] target;

  assign is_beq  = (op_i == OP_BEQ);
  assign is_bne  = (op_i == OP_BNE);
  assign is_br_o = is_beq || is_bne;
  assign same    = (a_i == b_i);
  assign cond    = (is_beq && same) || (is_bne && !same);
  // pc_i is the delay-slot address while the branch decodes
  assign target  = pc_i + {imm_i[XLEN-3:0], 2'b00};
  assign taken_o = cond && !hold_i;

  always_comb begin
    if (hold_i)       next_pc_o = pc_i;
    else if (taken_o) next_pc_o = target;
    else              next_pc_o = pc_i + STEP;
  end
endmodule

// File: rtl/br_resolve_top.sv
module br_resolve_top
  import br_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              RA_W     = 5,
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_BNE   = 6'h05,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic [OP_W-1:0] id_op_i,
  input  logic [RA_W-1:0] id_rs_i,
  input  logic [RA_W-1:0] id_rt_i,
  input  logic [XLEN-1:0] id_rs_val_i,
  input  logic [XLEN-1:0] id_rt_val_i,
  input  logic [XLEN-1:0] id_imm_i,
  input  logic            ex_wr_i,
  input  logic [RA_W-1:0] ex_rd_i,
  input  logic            mem_wr_i,
  input  logic            mem_ld_i,
  input  logic [RA_W-1:0] mem_rd_i,
  input  logic [XLEN-1:0] mem_val_i,
  input  logic            wb_wr_i,
  input  logic [RA_W-1:0] wb_rd_i,
  input  logic [XLEN-1:0] wb_val_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            stall_o,
  output logic [1:0]      fwd_a_o,
  output logic [1:0]      fwd_b_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][RA_W-1:0] src_idx;
  logic [NSRC-1:0][XLEN-1:0] src_rf, src_val;
  fwd_sel_e                  src_sel [NSRC];
  logic [NSRC-1:0]           src_haz;
  logic                      is_br, hold;
  logic [XLEN-1:0]           pc_q;

  assign src_idx = {id_rt_i, id_rs_i};
  assign src_rf  = {id_rt_val_i, id_rs_val_i};

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    br_opnd_fwd #(.XLEN(XLEN), .RA_W(RA_W)) u_fwd (
      .idx_i    (src_idx[k]),
      .rf_val_i (src_rf[k]),
      .ex_wr_i  (ex_wr_i),
      .ex_rd_i  (ex_rd_i),
      .mem_wr_i (mem_wr_i),
      .mem_ld_i (mem_ld_i),
      .mem_rd_i (mem_rd_i),
      .mem_val_i(mem_val_i),
      .wb_wr_i  (wb_wr_i),
      .wb_rd_i  (wb_rd_i),
      .wb_val_i (wb_val_i),
      .val_o    (src_val[k]),
      .sel_o    (src_sel[k]),
      .hazard_o (src_haz[k])
    );
  end

  // only branches consume operands in decode
  assign stall_o = is_br && (|src_haz);
  assign hold    = stall_o || stall_i;

  br_cmp_npc #(
    .XLEN(XLEN), .OP_W(OP_W), .OP_BEQ(OP_BEQ), .OP_BNE(OP_BNE)
  ) u_cmp (
    .op_i     (id_op_i),
    .a_i      (src_val[0]),
    .b_i      (src_val[1]),
    .pc_i     (pc_q),
    .imm_i    (id_imm_i),
    .hold_i   (hold),
    .is_br_o  (is_br),
    .taken_o  (taken_o),
    .next_pc_o(next_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= next_pc_o;
  end

  assign pc_o    = pc_q;
  assign fwd_a_o = src_sel[0];
  assign fwd_b_o = src_sel[1];
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int XLEN = 32,
  parameter int RA_W = 5,
  parameter int OP_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic [OP_W-1:0] id_op_i,
  input logic [RA_W-1:0] id_rs_i,
  input logic [RA_W-1:0] id_rt_i,
  input logic            mem_wr_i,
  input logic            mem_ld_i,
  input logic [RA_W-1:0] mem_rd_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            stall_o,
  input logic [1:0]      fwd_a_o,
  input logic [1:0]      fwd_b_o
);
  // R1
  pc_follows_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pc_o == $past(next_pc_o));

  // R7
  stall_blocks_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!taken_o && next_pc_o == pc_o));

  // R9
  ext_stall_holds_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(pc_o));

  // R9
  ext_stall_no_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !taken_o);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!taken_o && !stall_o && !stall_i) |=> pc_o == $past(pc_o) + XLEN'(4));

  // R8
  zero_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs_i == '0) |-> fwd_a_o == 2'd0);

  // R8
  zero_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rt_i == '0) |-> fwd_b_o == 2'd0);

  // R6
  mem_wins_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_i && !mem_ld_i && mem_rd_i == id_rs_i && id_rs_i != '0) |-> fwd_a_o == 2'd1);

  // R3
  taken_only_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (id_op_i == 6'h04 || id_op_i == 6'h05));
endmodule

bind br_resolve_top br_resolve_chk #(.XLEN(XLEN), .RA_W(RA_W), .OP_W(OP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stall_i  (stall_i),
  .id_op_i  (id_op_i),
  .id_rs_i  (id_rs_i),
  .id_rt_i  (id_rt_i),
  .mem_wr_i (mem_wr_i),
  .mem_ld_i (mem_ld_i),
  .mem_rd_i (mem_rd_i),
  .pc_o     (pc_o),
  .next_pc_o(next_pc_o),
  .taken_o  (taken_o),
  .stall_o  (stall_o),
  .fwd_a_o  (fwd_a_o),
  .fwd_b_o  (fwd_b_o)
);

// File: tb/tb_br_resolve_top.sv
module tb_br_resolve_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  rs, rt;
    logic [31:0] rsv, rtv, imm;
    logic        ex_wr;
    logic [4:0]  ex_rd;
    logic        mem_wr, mem_ld;
    logic [4:0]  mem_rd;
    logic [31:0] mem_val;
    logic        wb_wr;
    logic [4:0]  wb_rd;
    logic [31:0] wb_val;
    logic        e_tk, e_st;
    logic [1:0]  e_fa, e_fb;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    // R2 plain ALU op
    '{6'h00,5'd1,5'd2,32'd3,32'd4,32'd8, 1'b0,5'd0, 1'b0,1'b0,5'd0,32'd0, 1'b0,5'd0,32'd0, 1'b0,1'b0,2'd0,2'd0},
    // R3 equal taken
    '{6'h04,5'd1,5'd2,32'd5,32'd5,32'd4, 1'b0,5'd0, 1'b0,1'b0,5'd0,32'd0, 1'b0,5'd0,32'd0, 1'b1,1'b0,2'd0,2'd0},
    // R3 equal not taken
    '{6'h04,5'd1,5'd2,32'd5,32'd6,32'd4, 1'b0,5'd0, 1'b0,1'b0,5'd0,32'd0, 1'b0,5'd0,32'd0, 1'b0,1'b0,2'd0,2'd0},
    // R4 not-equal taken, backwards
    '{6'h05,5'd1,5'd2,32'd5,32'd6,32'hFFFF_FFFE, 1'b0,5'd0, 1'b0,1'b0,5'd0,32'd0, 1'b0,5'd0,32'd0, 1'b1,1'b0,2'd0,2'd0},
    // R4 not-equal not taken
    '{6'h05,5'd1,5'd2,32'd5,32'd5,32'd4, 1'b0,5'd0, 1'b0,1'b0,5'd0,32'd0, 1'b0,5'd0,32'd0, 1'b0,1'b0,2'd0,2'd0},
    // R5 memory bypass on a
    '{6'h04,5'd1,5'd2,32'd0,32'd7,32'd3, 1'b0,5'd0, 1'b1,1'b0,5'd1,32'd7, 1'b0,5'd0,32'd0, 1'b1,1'b0,2'd1,2'd0},
    // R5 writeback bypass on a
    '{6'h04,5'd3,5'd4,32'd0,32'd9,32'd1, 1'b0,5'd0, 1'b0,1'b0,5'd0,32'd0, 1'b1,5'd3,32'd9, 1'b1,1'b0,2'd2,2'd0},
    // R6 memory beats writeback
    '{6'h04,5'd1,5'd2,32'd0,32'd2,32'd2, 1'b0,5'd0, 1'b1,1'b0,5'd1,32'd2, 1'b1,5'd1,32'd8, 1'b1,1'b0,2'd1,2'd0},
    // R7 execute-stage writer
    '{6'h04,5'd1,5'd2,32'd5,32'd5,32'd2, 1'b1,5'd1, 1'b0,1'b0,5'd0,32'd0, 1'b0,5'd0,32'd0, 1'b0,1'b1,2'd0,2'd0},
    // R7 memory-stage load
    '{6'h05,5'd1,5'd2,32'd5,32'd6,32'd2, 1'b0,5'd0, 1'b1,1'b1,5'd2,32'd0, 1'b0,5'd0,32'd0, 1'b0,1'b1,2'd0,2'd0},
    // R8 register 0 everywhere
    '{6'h04,5'd0,5'd0,32'd0,32'd0,32'd1, 1'b1,5'd0, 1'b1,1'b0,5'd0,32'd5, 1'b1,5'd0,32'd6, 1'b1,1'b0,2'd0,2'd0},
    // R2 non-branch ignores hazard
    '{6'h23,5'd1,5'd2,32'd0,32'd0,32'd4, 1'b1,5'd1, 1'b0,1'b0,5'd0,32'd0, 1'b0,5'd0,32'd0, 1'b0,1'b0,2'd0,2'd0},
    // R5 writeback bypass on b, equal so not-equal falls through
    '{6'h05,5'd1,5'd2,32'd4,32'd0,32'd4, 1'b0,5'd0, 1'b0,1'b0,5'd0,32'd0, 1'b1,5'd2,32'd4, 1'b0,1'b0,2'd0,2'd2}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stall_i = 1'b0;
  logic [5:0]  id_op_i = '0;
  logic [4:0]  id_rs_i = '0, id_rt_i = '0;
  logic [31:0] id_rs_val_i = '0, id_rt_val_i = '0, id_imm_i = '0;
  logic        ex_wr_i = 1'b0;
  logic [4:0]  ex_rd_i = '0;
  logic        mem_wr_i = 1'b0, mem_ld_i = 1'b0;
  logic [4:0]  mem_rd_i = '0;
  logic [31:0] mem_val_i = '0;
  logic        wb_wr_i = 1'b0;
  logic [4:0]  wb_rd_i = '0;
  logic [31:0] wb_val_i = '0;
  logic [31:0] pc_o, next_pc_o;
  logic        taken_o, stall_o;
  logic [1:0]  fwd_a_o, fwd_b_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model_pc;
  logic [31:0] exp_np;

  br_resolve_top dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    id_op_i = v.op;  id_rs_i = v.rs;  id_rt_i = v.rt;
    id_rs_val_i = v.rsv;  id_rt_val_i = v.rtv;  id_imm_i = v.imm;
    ex_wr_i = v.ex_wr;  ex_rd_i = v.ex_rd;
    mem_wr_i = v.mem_wr;  mem_ld_i = v.mem_ld;  mem_rd_i = v.mem_rd;  mem_val_i = v.mem_val;
    wb_wr_i = v.wb_wr;  wb_rd_i = v.wb_rd;  wb_val_i = v.wb_val;
  endtask

  function automatic string tag(input int i);
    case (i)
      0, 11:      return "R2";
      1, 2:       return "R3";
      3, 4:       return "R4";
      5, 6, 12:   return "R5";
      7:          return "R6";
      8, 9:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD*20000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R1 reset pc", pc_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_pc = 32'h0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      #1;
      if (VEC[i].e_st)      exp_np = model_pc;
      else if (VEC[i].e_tk) exp_np = model_pc + {VEC[i].imm[29:0], 2'b00};
      else                  exp_np = model_pc + 32'd4;
      chk({tag(i), " taken"}, {31'b0, taken_o}, {31'b0, VEC[i].e_tk});
      chk({tag(i), " stall"}, {31'b0, stall_o}, {31'b0, VEC[i].e_st});
      chk({tag(i), " fwd a"}, {30'b0, fwd_a_o}, {30'b0, VEC[i].e_fa});
      chk({tag(i), " fwd b"}, {30'b0, fwd_b_o}, {30'b0, VEC[i].e_fb});
      chk({tag(i), " next pc"}, next_pc_o, exp_np);
      @(posedge clk_i);
      #1;
      model_pc = exp_np;
      chk("R1 pc load", pc_o, model_pc);
      @(negedge clk_i);
    end

    // R9 external stall over a taken branch
    apply(VEC[1]);
    stall_i = 1'b1;
    #1;
    chk("R9 taken while frozen", {31'b0, taken_o}, 32'h0);
    chk("R9 next pc held", next_pc_o, model_pc);
    @(posedge clk_i);
    #1;
    chk("R9 pc held", pc_o, model_pc);
    @(negedge clk_i);
    stall_i = 1'b0;
    #1;
    chk("R9 taken after release", {31'b0, taken_o}, 32'h1);
    @(posedge clk_i);
    #1;
    model_pc = model_pc + 32'd16;
    chk("R9 redirect after release", pc_o, model_pc);

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", pc_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule